// File: doc/BRIEF.md
# Dual-port RAM with same-address collision arbitration

This block is a clocked true dual-port memory of 2048 words by 8 bits, with two independent ports called left and right. Each port has its own address, write data, read data, an active-low select, an active-low write strobe and an active-low output enable. Both ports can read any location at the same time, and that includes the same location.

When both selected ports point at the same word, an arbiter decides which one owns it. The port that was already on that address in the previous clock cycle wins. If both arrive in the same cycle, the left port wins. The losing port sees its active-low busy flag go low and its write is dropped. While the owner writes the shared word, the loser's registered read data is frozen. The ownership is kept in a register for as long as the collision lasts. It is released when the addresses differ or when the owner deselects.

A cascade parameter turns the block into a follower for width expansion. In that mode the arbiter is not built, both busy outputs stay high, and the busy inputs gate the writes of each port, driven by a leading device that holds the same addresses.

Top module: `dpr_collision_ram`

## Requirements
- R1: During and right after reset, both busy outputs are high, both `*_dout_en_o` are low and both `*_rdata_o` are 0.
- R2: At a rising edge where a port has `cs_ni`=0 and `we_ni`=0 and is not blocked, `wdata_i` is stored at `addr_i`. After that edge, `dout_en_o` of the port is 0.
- R3: At a rising edge where a port has `cs_ni`=0 and `we_ni`=1, `rdata_o` loads the word stored before any write of that same edge. After the edge, `dout_en_o` is 1 only if `oe_ni` was also 0. An unselected port keeps its `rdata_o`.
- R4: Two ports reading the same address in the same cycle both receive the stored word.
- R5: In normal mode, a busy output goes low in the same cycle as the collision only when both ports are selected on equal addresses. The two busy outputs are never low together.
- R6: The port that was selected on the colliding address in the previous cycle keeps the word, and the other port's busy goes low. This holds for either side.
- R7: When both ports start a collision in the same cycle, the left port wins, so `r_busy_no`=0.
- R8: The winner stays fixed while the match lasts. Busy returns high in the cycle the addresses differ or the winner raises `cs_ni`.
- R9: A write from a port whose busy is low does not change memory. The winner's data remains.
- R10: While the owner writes the shared word, the loser's `rdata_o` holds its value. It updates at the first read edge after busy returns high.
- R11: With `CASCADE`=1, both busy outputs stay high and a low `*_busy_ni` blocks that port's write. With `CASCADE`=0, `*_busy_ni` has no effect.
- R12: With `CASCADE`=1, if both ports write the same address at the same edge, the left word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_cs_ni | input | 1 | Left select, active low |
| l_we_ni | input | 1 | Left write strobe, active low |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_addr_i | input | ADDR_W | Left word address |
| l_wdata_i | input | DATA_W | Left write data |
| l_busy_ni | input | 1 | Left write gate in cascade mode, active low |
| l_rdata_o | output | DATA_W | Left registered read data |
| l_dout_en_o | output | 1 | Left read data drive enable |
| l_busy_no | output | 1 | Left collision flag, active low |
| r_cs_ni | input | 1 | Right select, active low |
| r_we_ni | input | 1 | Right write strobe, active low |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_addr_i | input | ADDR_W | Right word address |
| r_wdata_i | input | DATA_W | Right write data |
| r_busy_ni | input | 1 | Right write gate in cascade mode, active low |
| r_rdata_o | output | DATA_W | Right registered read data |
| r_dout_en_o | output | 1 | Right read data drive enable |
| r_busy_no | output | 1 | Right collision flag, active low |

## Verification
The assertions assume that all port inputs are settled well before each rising edge, that reset is applied with both ports deselected, and that memory is only read at addresses that were written earlier. The bench changes every input two nanoseconds after a rising edge and samples the combinational busy flags one nanosecond later. It holds both selects high during reset and reads only words it has written, so the unreset array never feeds a checked value. A follower copy shares the same stimulus, and its busy inputs are driven on their own so that the write gating can be isolated.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_L    = 2'd1,
    OWN_R    = 2'd2
  } owner_e;
endpackage

// File: rtl/dpr_mem_core.sv
module dpr_mem_core #(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter bit CASCADE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_we_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // left written last so it wins an unarbitrated same-address write
  always_ff @(posedge clk_i) begin
    if (r_we_i) mem_q[r_addr_i] <= r_wdata_i;
    if (l_we_i) mem_q[l_addr_i] <= l_wdata_i;
  end

  assign l_rdata_o = mem_q[l_addr_i];
  assign r_rdata_o = mem_q[r_addr_i];

  AST_NO_SAME_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_we_i && r_we_i && !CASCADE) |-> (l_addr_i != r_addr_i)); // R9
endmodule

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_act_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              r_act_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  output logic              l_busy_o,
  output logic              r_busy_o
);
  owner_e            owner_q, owner_d;
  logic              l_act_q, r_act_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  logic              match, l_held, r_held;

  assign match  = l_act_i && r_act_i && (l_addr_i == r_addr_i);
  assign l_held = l_act_i && l_act_q && (l_addr_q == l_addr_i);
  assign r_held = r_act_i && r_act_q && (r_addr_q == r_addr_i);

  always_comb begin
    owner_d = OWN_NONE;
    if (match) begin
      if (owner_q != OWN_NONE) owner_d = owner_q;
      else if (r_held && !l_held) owner_d = OWN_R;
      else owner_d = OWN_L;
    end
  end

  assign l_busy_o = match && (owner_d == OWN_R);
  assign r_busy_o = match && (owner_d == OWN_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q  <= OWN_NONE;
      l_act_q  <= 1'b0;
      r_act_q  <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
    end else begin
      owner_q  <= owner_d;
      l_act_q  <= l_act_i;
      r_act_q  <= r_act_i;
      l_addr_q <= l_addr_i;
      r_addr_q <= r_addr_i;
    end
  end

  AST_BUSY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(l_busy_o && r_busy_o)); // R5
  AST_TIE_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !$past(l_act_i) && !$past(r_act_i)) |-> r_busy_o); // R7
  AST_HOLD_L: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && $past(match) && $past(l_busy_o)) |-> l_busy_o); // R8
  AST_HOLD_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && $past(match) && $past(r_busy_o)) |-> r_busy_o); // R8
endmodule

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              wr_block_i,
  input  logic              rd_hold_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              act_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dout_en_o
);
  logic rd_en;

  assign act_o   = !cs_ni;
  assign wr_en_o = act_o && !we_ni && !wr_block_i;
  assign rd_en   = act_o && we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      dout_en_o <= 1'b0;
    end else begin
      if (rd_en && !rd_hold_i) rdata_o <= mem_rdata_i;
      dout_en_o <= rd_en && !oe_ni;
    end
  end

  AST_WR_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !dout_en_o); // R2
endmodule

// File: rtl/dpr_collision_ram.sv
module dpr_collision_ram #(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter bit CASCADE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_cs_ni,
  input  logic              l_we_ni,
  input  logic              l_oe_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic              l_busy_ni,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_dout_en_o,
  output logic              l_busy_no,
  input  logic              r_cs_ni,
  input  logic              r_we_ni,
  input  logic              r_oe_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  input  logic              r_busy_ni,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_dout_en_o,
  output logic              r_busy_no
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]  cs_n, we_n, oe_n, busy_in_n;
  logic [NPORT-1:0]  act, wr_en, arb_busy, wr_block, rd_hold, dout_en;
  logic [ADDR_W-1:0] addr  [NPORT];
  logic [DATA_W-1:0] wdata [NPORT];
  logic [DATA_W-1:0] mrd   [NPORT];
  logic [DATA_W-1:0] rdata [NPORT];

  assign cs_n      = {r_cs_ni, l_cs_ni};
  assign we_n      = {r_we_ni, l_we_ni};
  assign oe_n      = {r_oe_ni, l_oe_ni};
  assign busy_in_n = {r_busy_ni, l_busy_ni};
  assign addr[0]   = l_addr_i;
  assign addr[1]   = r_addr_i;
  assign wdata[0]  = l_wdata_i;
  assign wdata[1]  = r_wdata_i;

  generate
    if (CASCADE) begin : g_follow
      assign arb_busy = '0;
      assign wr_block = ~busy_in_n;
    end else begin : g_lead
      dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .l_act_i  (act[0]),
        .l_addr_i (addr[0]),
        .r_act_i  (act[1]),
        .r_addr_i (addr[1]),
        .l_busy_o (arb_busy[0]),
        .r_busy_o (arb_busy[1])
      );
      assign wr_block = arb_busy;
    end
  endgenerate

  // loser read freezes only while the owner writes the shared word
  assign rd_hold[0] = arb_busy[0] && wr_en[1];
  assign rd_hold[1] = arb_busy[1] && wr_en[0];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpr_port_ctrl #(.DATA_W(DATA_W)) u_port (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cs_ni       (cs_n[p]),
      .we_ni       (we_n[p]),
      .oe_ni       (oe_n[p]),
      .wr_block_i  (wr_block[p]),
      .rd_hold_i   (rd_hold[p]),
      .mem_rdata_i (mrd[p]),
      .act_o       (act[p]),
      .wr_en_o     (wr_en[p]),
      .rdata_o     (rdata[p]),
      .dout_en_o   (dout_en[p])
    );
  end

  dpr_mem_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CASCADE(CASCADE)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .l_we_i    (wr_en[0]),
    .l_addr_i  (addr[0]),
    .l_wdata_i (wdata[0]),
    .l_rdata_o (mrd[0]),
    .r_we_i    (wr_en[1]),
    .r_addr_i  (addr[1]),
    .r_wdata_i (wdata[1]),
    .r_rdata_o (mrd[1])
  );

  assign l_rdata_o   = rdata[0];
  assign r_rdata_o   = rdata[1];
  assign l_dout_en_o = dout_en[0];
  assign r_dout_en_o = dout_en[1];
  assign l_busy_no   = !arb_busy[0];
  assign r_busy_no   = !arb_busy[1];

  AST_RD_HOLD_L: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_busy_no && wr_en[1]) |=> $stable(l_rdata_o)); // R10
  AST_RD_HOLD_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_busy_no && wr_en[0]) |=> $stable(r_rdata_o)); // R10
  AST_FOLLOW_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CASCADE |-> (l_busy_no && r_busy_no)); // R11
endmodule

// File: tb/sim_dpr_collision_ram.sv
`timescale 1ns/1ps
module sim_dpr_collision_ram;
  localparam int AW = 11;
  localparam int DW = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic l_cs = 1'b1, l_we = 1'b1, l_oe = 1'b1;
  logic r_cs = 1'b1, r_we = 1'b1, r_oe = 1'b1;
  logic [AW-1:0] l_a = '0, r_a = '0;
  logic [DW-1:0] l_d = '0, r_d = '0;
  logic m_lb = 1'b1, s_lb = 1'b1, s_rb = 1'b1;

  logic [DW-1:0] m_lq, m_rq, s_lq, s_rq;
  logic m_len, m_ren, s_len, s_ren, m_lbo, m_rbo, s_lbo, s_rbo;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  dpr_collision_ram #(.ADDR_W(AW), .DATA_W(DW), .CASCADE(1'b0)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .l_cs_ni(l_cs), .l_we_ni(l_we), .l_oe_ni(l_oe), .l_addr_i(l_a), .l_wdata_i(l_d),
    .l_busy_ni(m_lb), .l_rdata_o(m_lq), .l_dout_en_o(m_len), .l_busy_no(m_lbo),
    .r_cs_ni(r_cs), .r_we_ni(r_we), .r_oe_ni(r_oe), .r_addr_i(r_a), .r_wdata_i(r_d),
    .r_busy_ni(1'b1), .r_rdata_o(m_rq), .r_dout_en_o(m_ren), .r_busy_no(m_rbo));

  dpr_collision_ram #(.ADDR_W(AW), .DATA_W(DW), .CASCADE(1'b1)) u1 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .l_cs_ni(l_cs), .l_we_ni(l_we), .l_oe_ni(l_oe), .l_addr_i(l_a), .l_wdata_i(l_d),
    .l_busy_ni(s_lb), .l_rdata_o(s_lq), .l_dout_en_o(s_len), .l_busy_no(s_lbo),
    .r_cs_ni(r_cs), .r_we_ni(r_we), .r_oe_ni(r_oe), .r_addr_i(r_a), .r_wdata_i(r_d),
    .r_busy_ni(s_rb), .r_rdata_o(s_rq), .r_dout_en_o(s_ren), .r_busy_no(s_rbo));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic drv_l(input logic cs, input logic we, input logic oe,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_cs = cs; l_we = we; l_oe = oe; l_a = a; l_d = d;
  endtask

  task automatic drv_r(input logic cs, input logic we, input logic oe,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_cs = cs; r_we = we; r_oe = oe; r_a = a; r_d = d;
  endtask

  task automatic idle();
    drv_l(1, 1, 1, '0, '0);
    drv_r(1, 1, 1, '0, '0);
    tick();
  endtask

  task automatic t_reset();
    check("R1 l_busy", m_lbo, 1);
    check("R1 r_busy", m_rbo, 1);
    check("R1 l_dout_en", m_len, 0);
    check("R1 r_dout_en", m_ren, 0);
    check("R1 l_rdata", m_lq, 0);
    check("R1 r_rdata", m_rq, 0);
  endtask

  task automatic t_basic();
    drv_l(0, 0, 0, 11'd5, 8'hA5); tick();
    check("R2 dout_en after write", m_len, 0);
    drv_l(1, 1, 1, '0, '0);
    drv_r(0, 1, 0, 11'd5, '0); tick();
    check("R3 r_rdata", m_rq, 8'hA5);
    check("R3 r_dout_en", m_ren, 1);
    drv_r(0, 1, 1, 11'd5, '0); tick();
    check("R3 dout_en oe high", m_ren, 0);
    drv_r(1, 1, 0, 11'd7, '0); tick();
    check("R3 unselected holds", m_rq, 8'hA5);
    idle();
  endtask

  task automatic t_priority();
    drv_l(0, 0, 0, 11'd9, 8'h10); tick();
    drv_l(0, 1, 0, 11'd9, '0); tick();
    drv_r(0, 1, 0, 11'd9, '0); #1;
    check("R6 left first r_busy", m_rbo, 0);
    check("R5 l_busy", m_lbo, 1);
    tick();
    check("R4 loser read", m_rq, 8'h10);
    check("R4 owner read", m_lq, 8'h10);
    drv_r(0, 0, 0, 11'd9, 8'h33); #1;
    check("R8 held", m_rbo, 0);
    tick();
    drv_r(0, 1, 0, 11'd9, '0); tick();
    check("R9 blocked write", m_lq, 8'h10);
    drv_l(0, 0, 0, 11'd9, 8'h44); tick();
    drv_l(0, 0, 0, 11'd9, 8'h55); tick();
    check("R10 loser held", m_rq, 8'h10);
    drv_l(1, 1, 1, 11'd9, '0); #1;
    check("R8 owner deselect", m_rbo, 1);
    tick();
    check("R10 update after release", m_rq, 8'h55);
    drv_l(0, 1, 0, 11'd9, '0); #1;
    check("R6 right first l_busy", m_lbo, 0);
    check("R5 r_busy", m_rbo, 1);
    tick();
    drv_r(0, 1, 0, 11'd10, '0); #1;
    check("R8 mismatch release", m_lbo, 1);
    tick();
    idle();
  endtask

  task automatic t_tie();
    drv_l(0, 0, 0, 11'd30, 8'hA1);
    drv_r(0, 0, 0, 11'd30, 8'hB2); #1;
    check("R7 tie r_busy", m_rbo, 0);
    check("R7 tie l_busy", m_lbo, 1);
    tick();
    drv_l(0, 1, 0, 11'd30, '0);
    drv_r(0, 1, 0, 11'd30, '0); #1;
    check("R8 owner kept", m_rbo, 0);
    tick();
    check("R9 tie l data", m_lq, 8'hA1);
    check("R4 tie r data", m_rq, 8'hA1);
    idle();
  endtask

  task automatic t_cascade();
    m_lb = 1'b0; s_lb = 1'b1;
    drv_l(0, 0, 0, 11'd100, 8'h11); tick();
    s_lb = 1'b0;
    drv_l(0, 0, 0, 11'd100, 8'h22); tick();
    s_lb = 1'b1;
    drv_l(0, 1, 0, 11'd100, '0); tick();
    check("R11 follower write blocked", s_lq, 8'h11);
    check("R11 lead ignores busy_ni", m_lq, 8'h22);
    m_lb = 1'b1;
    drv_l(0, 0, 0, 11'd101, 8'h5A);
    drv_r(0, 0, 0, 11'd101, 8'hA5); #1;
    check("R11 follower l_busy high", s_lbo, 1);
    check("R11 follower r_busy high", s_rbo, 1);
    tick();
    drv_l(0, 1, 0, 11'd101, '0);
    drv_r(1, 1, 1, '0, '0); tick();
    check("R12 follower tie", s_lq, 8'h5A);
    check("R7 lead tie", m_lq, 8'h5A);
    idle();
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_priority();
    t_tie();
    t_cascade();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule